// File: doc/BRIEF.md
# Programmable Baud-Rate Clock Divider

This block derives a slow clock from one of several sources by counting source edges. One control register holds everything about the channel: which source to count, the divide value, an optional divide-by-16 prescaler, an enable and a software reset. The host writes the register through a full-word write port or through a narrower port that updates only the divide value, and it reads the register back through a synchronous read port.

A source edge is every system clock cycle when the internal reference is selected. With an external pin selected, a source edge is a rising edge of that pin after it has passed through a two-flop synchronizer. The block produces a one-cycle strobe each time the divider completes a period. It also produces a square-wave level that is low for the first half of each period and high for the rest.

Top module: `baud_clk_gen`

## Requirements
- R1: After `rst_n` is released, the register reads 0 and `tick_o` and `clk_o` are low.
- R2: Register layout: bit 0 is the prescale enable, bits 12:1 hold the divide value N, bits 14:13 select the source, bit 15 is the enable, and bit 16 is the software reset. All other bits ignore writes and read as 0. A read started with `rd_en` returns its data on `rd_data` one cycle later.
- R3: A `cnt_wr_en` write changes only bits 12:1. The prescale, source, enable and reset bits keep their values. If both write ports are used in the same cycle, the full write takes effect.
- R4: With the prescaler off, `tick_o` pulses once every N+1 source edges. A stored 0 gives a pulse on every edge.
- R5: With the prescaler on, `tick_o` pulses once every (N+1)*16 source edges.
- R6: Source codes 0 and 3 count every system clock cycle. Code 1 counts rising edges of `ext_clk[0]` and code 2 counts rising edges of `ext_clk[1]`. The pin that is not selected has no effect.
- R7: With D = N+1, `clk_o` is high while the counter is at or above floor(D/2). It is therefore high for D - floor(D/2) counter steps of every D.
- R8: While the reset bit is set, the counter and the prescaler are held at zero and both outputs are low. After the bit is cleared, the counter starts from zero, and the first `tick_o` comes on the (N+1)-th counter step.
- R9: While the enable bit is clear, both outputs are low and the counter holds its value. When the bit is set again, counting resumes from the held value.
- R10: The divider reaches its terminal count whenever the counter is at or above N. If N is lowered below the current count, the counter wraps on the next counter step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Full-register write strobe |
| wr_data | input | 32 | Full-register write data |
| cnt_wr_en | input | 1 | Divide-value-only write strobe |
| cnt_wr_val | input | 12 | New divide value N |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Register contents, valid the cycle after `rd_en` |
| ext_clk | input | 2 | External clock pins, asynchronous |
| tick_o | output | 1 | One-cycle strobe at the terminal count |
| clk_o | output | 1 | Divided square-wave level |

## Verification
The assertions check the following on every cycle:
- the counter steps by exactly one, or wraps to zero at its terminal count;
- the counter stays still when there is no edge and while the enable bit is clear;
- the reset bit clears the counter;
- a synchronized pin never produces two edge pulses in a row;
- a divide-value write leaves the other control fields untouched.

Only the bench scenarios can show the resulting rates and duty cycles over whole periods, which pin each source code really counts, the latency from clearing the reset bit or setting the enable bit to the next strobe, and the register layout as seen at the read port.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int REG_W   = 32;
  localparam int CNT_W   = 12;
  localparam int PRE_W   = 4;
  localparam int SRC_W   = 2;
  localparam int NUM_EXT = 2;

  typedef struct packed {
    logic             rst;
    logic             en;
    logic [SRC_W-1:0] src;
    logic [CNT_W-1:0] cnt;
    logic             pre;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // floor((n+1)/2): the counter value at which the square output goes high
  function automatic logic [CNT_W-1:0] half_of(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] d;
    d = {1'b0, n} + 1'b1;
    return d[CNT_W:1];
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
    return {{(REG_W-CTRL_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/baud_edge_sync.sv
module baud_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], async_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/baud_ctrl_reg.sv
module baud_ctrl_reg
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_val,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  output ctrl_t            ctrl
);
  ctrl_t            ctrl_q;
  logic [REG_W-1:0] rd_q;
  logic             unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (!rst_n)         ctrl_q     <= '0;
    else if (wr_en)     ctrl_q     <= ctrl_t'(wr_data[CTRL_W-1:0]);
    else if (cnt_wr_en) ctrl_q.cnt <= cnt_wr_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= pack_ctrl(ctrl_q);
  end

  assign rd_data = rd_q;
  assign ctrl    = ctrl_q;

  p_cnt_write_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_en && !wr_en) |=> (ctrl_q.cnt == $past(cnt_wr_val)) && $stable(ctrl_q.pre)
      && $stable(ctrl_q.src) && $stable(ctrl_q.en) && $stable(ctrl_q.rst));
endmodule

// File: rtl/baud_div_core.sv
module baud_div_core
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             en,
  input  logic             pre_on,
  input  logic [CNT_W-1:0] div_n,
  input  logic             src_edge,
  output logic             tick_o,
  output logic             clk_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run, pre_wrap, cnt_edge, at_term;

  assign run      = en & ~soft_rst;
  assign pre_wrap = &pre_q;
  assign cnt_edge = src_edge & (~pre_on | pre_wrap);
  assign at_term  = (cnt_q >= div_n);

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run) begin
      if (src_edge && pre_on) pre_q <= pre_q + 1'b1;
      if (cnt_edge)           cnt_q <= at_term ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = run & cnt_edge & at_term;
  assign clk_o  = run & (cnt_q >= half_of(div_n));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_edge && !at_term) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_edge) |=> $stable(cnt_q));
  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_edge && at_term) |=> cnt_q == '0);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> cnt_q == '0 && pre_q == '0);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !soft_rst) |=> $stable(cnt_q));
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
  import baud_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               cnt_wr_en,
  input  logic [CNT_W-1:0]   cnt_wr_val,
  input  logic               rd_en,
  output logic [REG_W-1:0]   rd_data,
  input  logic [NUM_EXT-1:0] ext_clk,
  output logic               tick_o,
  output logic               clk_o
);
  ctrl_t              ctrl;
  logic [NUM_EXT-1:0] ext_rise;
  logic               src_edge;

  baud_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_val(cnt_wr_val),
    .rd_en(rd_en), .rd_data(rd_data), .ctrl(ctrl)
  );

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    baud_edge_sync u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ext_clk[g]), .rise_o(ext_rise[g])
    );
  end

  // code k+1 selects pin k; every other code counts the system clock
  always_comb begin
    src_edge = 1'b1;
    for (int k = 0; k < NUM_EXT; k++)
      if (ctrl.src == SRC_W'(k + 1)) src_edge = ext_rise[k];
  end

  baud_div_core u_core (
    .clk(clk), .rst_n(rst_n), .soft_rst(ctrl.rst), .en(ctrl.en),
    .pre_on(ctrl.pre), .div_n(ctrl.cnt), .src_edge(src_edge),
    .tick_o(tick_o), .clk_o(clk_o)
  );
endmodule

// File: tb/tb_baud_clk_gen.sv
module tb_baud_clk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        cnt_wr_en = 1'b0;
  logic [11:0] cnt_wr_val = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [1:0]  ext_clk = 2'b00;
  logic [1:0]  ext_on = 2'b00;
  logic        tick_o, clk_o;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5ns clk = ~clk;

  baud_clk_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_val(cnt_wr_val), .rd_en(rd_en),
    .rd_data(rd_data), .ext_clk(ext_clk), .tick_o(tick_o), .clk_o(clk_o)
  );

  // external pins: period of 6 system cycles when switched on
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      for (int i = 0; i < 2; i++) ext_clk[i] = ext_on[i] && ((ph / 3) % 2 == 1);
    end
  end

  // R2 field positions
  function automatic logic [31:0] mk(input bit pre, input int n, input int src,
                                     input bit en, input bit rs);
    return (32'(pre)) | (32'(n & 12'hFFF) << 1) | (32'(src & 3) << 13)
         | (32'(en) << 15) | (32'(rs) << 16);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks are entered and left at a falling edge
  task automatic write_reg(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_cnt(input int n);
    cnt_wr_en = 1'b1; cnt_wr_val = 12'(n);
    @(posedge clk); @(negedge clk);
    cnt_wr_en = 1'b0;
  endtask

  task automatic read_reg(output logic [31:0] v);
    rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic measure(input int w, output int ticks, output int highs);
    ticks = 0; highs = 0;
    for (int i = 0; i < w; i++) begin
      ticks += int'(tick_o);
      highs += int'(clk_o);
      @(negedge clk);
    end
  endtask

  task automatic steps_to_tick(output int k);
    k = 0;
    while (!tick_o && k < 1000) begin @(negedge clk); k++; end
  endtask

  task automatic rate_case(input string req, input logic [31:0] cfg, input int w,
                           input int exp_t, input int exp_h);
    int t, h;
    write_reg(cfg);
    repeat (40) @(negedge clk);
    measure(w, t, h);
    check({req, " ticks"}, t, exp_t);
    if (exp_h >= 0) check({req, " high"}, h, exp_h);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 tick", tick_o, 0);
    check("R1 clk", clk_o, 0);
    read_reg(v);
    check("R1 reg", v, 0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    write_reg(32'hFFFF_FFFF);
    read_reg(v);
    check("R2 readback", v, 32'h0001_FFFF);
    check("R2 quiet while rst", tick_o, 0);
    write_reg(32'h0);
    read_reg(v);
    check("R2 cleared", v, 0);
  endtask

  task automatic t_cnt_write();
    logic [31:0] v;
    write_reg(mk(1, 12'h123, 2, 1, 1));
    write_cnt(12'hABC);
    read_reg(v);
    check("R3 count write", v, mk(1, 12'hABC, 2, 1, 1));
    cnt_wr_en = 1'b1; cnt_wr_val = 12'h555;
    write_reg(mk(0, 7, 1, 0, 1));
    cnt_wr_en = 1'b0;
    read_reg(v);
    check("R3 full write wins", v, mk(0, 7, 1, 0, 1));
  endtask

  task automatic t_internal();
    rate_case("R4 R7 N=3", mk(0, 3, 0, 1, 0), 40, 10, 20);
    rate_case("R7 N=4", mk(0, 4, 0, 1, 0), 50, 10, 30);
    rate_case("R4 N=0", mk(0, 0, 0, 1, 0), 20, 20, 20);
  endtask

  task automatic t_prescale();
    rate_case("R5 pre N=1", mk(1, 1, 0, 1, 0), 320, 10, 160);
  endtask

  task automatic t_sources();
    rate_case("R6 code3", mk(0, 3, 3, 1, 0), 40, 10, 20);
    ext_on = 2'b01;
    rate_case("R6 code1 pin0", mk(0, 1, 1, 1, 0), 120, 10, -1);
    ext_on = 2'b10;
    rate_case("R6 code1 ignores pin1", mk(0, 1, 1, 1, 0), 60, 0, -1);
    rate_case("R6 code2 pin1", mk(0, 1, 2, 1, 0), 120, 10, -1);
    ext_on = 2'b00;
  endtask

  task automatic t_soft_rst();
    int t, h, k;
    write_reg(mk(0, 9, 0, 1, 0));
    repeat (13) @(negedge clk);
    write_reg(mk(0, 9, 0, 1, 1));
    measure(20, t, h);
    check("R8 no tick in rst", t, 0);
    check("R8 clk low in rst", h, 0);
    write_reg(mk(0, 9, 0, 1, 0));
    steps_to_tick(k);
    check("R8 first tick step", k, 9);
  endtask

  task automatic t_enable();
    int t, h, k;
    write_reg(mk(0, 9, 0, 1, 0));
    steps_to_tick(k);
    repeat (8) @(negedge clk);
    write_reg(mk(0, 9, 0, 0, 0));
    measure(20, t, h);
    check("R9 no tick off", t, 0);
    check("R9 clk low off", h, 0);
    write_reg(mk(0, 9, 0, 1, 0));
    check("R9 held count high", clk_o, 1);
    steps_to_tick(k);
    check("R9 resume step", k, 1);
  endtask

  task automatic t_lower();
    int t, h, k;
    write_reg(mk(0, 9, 0, 1, 0));
    steps_to_tick(k);
    repeat (8) @(negedge clk);
    write_cnt(3);
    check("R10 wrap at once", tick_o, 1);
    @(negedge clk);
    measure(40, t, h);
    check("R10 new rate", t, 10);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_cnt_write();
    t_internal();
    t_prescale();
    t_sources();
    t_soft_rst();
    t_enable();
    t_lower();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule